// File: doc/BRIEF.md
# Cache Tag Store with Compare

This block is the tag half of a direct-mapped secondary cache. Every index holds a stored tag together with a valid bit and a dirty bit. The cache controller places an index and a tag on the block's inputs. Within the same cycle, without waiting for a clock edge, the block reports whether that tag hits the stored entry. It also reports whether the addressed line is dirty.

The tag lines form one shared bidirectional bus. The controller drives the bus to compare a tag or to write one. The block drives the bus when the controller reads a stored tag back. All control inputs are active low:

- a write strobe
- an output enable for the tag bus
- a clear

Writes take place on the rising clock edge. Reads and compares are combinational. A clear invalidates every entry in one clock edge. Combinations of the controls that are not legal are dropped, so they never corrupt the stored contents. A reset input gives the status bits a known empty state at power-on.

Top module: `cache_tag_ram`

## Requirements
- R1: On a rising clock edge where `wr_n` is 0, `oe_n` is 1 and `clr_n` is 1, the entry at `idx` takes the tag from `tag_io` and the status bits from `vld_i` and `dty_i`. The one exception is the edge covered by R10.
- R2: When `oe_n` is 0 and both `wr_n` and `clr_n` are 1, the block drives the stored tag of entry `idx` onto `tag_io` with no clock edge involved. In this state `hit` is 0.
- R3: In compare mode (`oe_n`, `wr_n` and `clr_n` all 1), `hit` is 1 exactly when `tag_io` equals the stored tag and the stored valid bit is 1.
- R4: An entry whose valid bit is 0 never gives `hit` = 1, even when its stored tag equals `tag_io`.
- R5: When `wr_n` and `clr_n` are both 1, `dirty_o` shows the stored dirty bit of entry `idx`.
- R6: While `wr_n` is 0 and `clr_n` is 1:
  - `hit` is 0;
  - `dirty_o` follows `dty_i` directly;
  - the block does not drive `tag_io`, which carries the applied tag.
- R7: A write strobe with `oe_n` at 0 is dropped. The entry keeps its tag and status bits, and the block does not drive `tag_io`.
- R8: A rising edge with `clr_n` at 0 sets the valid and dirty bits of every entry to 0. While `clr_n` is 0, `hit` and `dirty_o` are 0 and `tag_io` is high-impedance.
- R9: On an edge where `clr_n` and `wr_n` are both 0, the clear still takes effect and the write is dropped.
- R10: On the first rising edge after `clr_n` returns to 1, no write is accepted.
- R11: While `rst_n` is 0, every valid and dirty bit is 0. After release, no entry hits and `dirty_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and clears act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the status bits |
| idx | input | IDX_W | Cache index that selects the entry |
| tag_io | inout | TAG_W | Tag bus: the controller drives it for a compare or a write, the block drives it for a read |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low tag bus output enable |
| clr_n | input | 1 | Active-low bulk invalidate, sampled on the clock edge |
| vld_i | input | 1 | Valid bit to store on a write |
| dty_i | input | 1 | Dirty bit to store on a write; passed through to `dirty_o` during a write |
| hit | output | 1 | Tag match with valid entry |
| dirty_o | output | 1 | Dirty bit of the addressed entry |

## Verification
The bench builds the block with DEPTH = 16 and TAG_W = 8. With these values, every entry can be filled and then swept after a clear. This shows that a single clear edge reaches all indices, including the entry whose write fell on the blocked edge after clear release. The narrow tag lets tags that differ in one bit sit next to matching ones. The bench also drives the illegal control combinations (a write with the bus enabled, and a write during clear). It then reads the entry back through the bus and the compare path to show that nothing changed.

// File: rtl/cache_tag_ram.sv
module cache_tag_ram #(
  parameter int DEPTH = 64,
  parameter int TAG_W = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  inout  wire  [TAG_W-1:0] tag_io,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic             clr_n,
  input  logic             vld_i,
  input  logic             dty_i,
  output logic             hit,
  output logic             dirty_o
);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] dty_q;
  logic             clr_seen_q;

  wire do_wr  = !wr_n && oe_n && clr_n && !clr_seen_q;
  wire rd_en  = !oe_n && wr_n && clr_n;
  wire cmp_en = oe_n && wr_n && clr_n;

  assign tag_io  = rd_en ? tag_mem[idx] : {TAG_W{1'bz}};
  assign hit     = cmp_en && vld_q[idx] && (tag_io == tag_mem[idx]);
  assign dirty_o = !clr_n ? 1'b0 : (!wr_n ? dty_i : dty_q[idx]);

  always_ff @(posedge clk) begin
    if (do_wr) tag_mem[idx] <= tag_io;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= '0;
      dty_q      <= '0;
      clr_seen_q <= 1'b0;
    end else begin
      clr_seen_q <= !clr_n;
      if (!clr_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else if (do_wr) begin
        vld_q[idx] <= vld_i;
        dty_q[idx] <= dty_i;
      end
    end
  end

endmodule

module cache_tag_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_n,
  input logic oe_n,
  input logic clr_n,
  input logic dty_i,
  input logic hit,
  input logic dirty_o
);

  a_r2_read_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && wr_n) |-> !hit);

  a_r6_write_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && clr_n) |-> (!hit && (dirty_o == dty_i)));

  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (!hit && !dirty_o));

  a_r10_empty_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr_n) && clr_n && wr_n) |-> (!hit && !dirty_o));

endmodule

bind cache_tag_ram cache_tag_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .oe_n(oe_n), .clr_n(clr_n),
  .dty_i(dty_i), .hit(hit), .dirty_o(dirty_o)
);

// File: tb/tb_cache_tag_ram.sv
module tb_cache_tag_ram;
  localparam int DEPTH = 16;
  localparam int TAG_W = 8;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDX_W-1:0] idx = '0;
  wire  [TAG_W-1:0] tag_io;
  logic [TAG_W-1:0] tb_tag = '0;
  logic tb_drv = 1'b0;
  logic wr_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1, vld_i = 1'b0, dty_i = 1'b0;
  logic hit, dirty_o;

  assign tag_io = tb_drv ? tb_tag : {TAG_W{1'bz}};

  always #4 clk = ~clk;

  cache_tag_ram #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .tag_io(tag_io), .wr_n(wr_n),
    .oe_n(oe_n), .clr_n(clr_n), .vld_i(vld_i), .dty_i(dty_i),
    .hit(hit), .dirty_o(dirty_o)
  );

  typedef struct {
    logic             h;
    logic             d;
    logic [TAG_W-1:0] bus;
    string            req;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [DEPTH-1:0] m_v = '0;
  logic [DEPTH-1:0] m_d = '0;
  bit m_clr_prev = 0;

  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (hit !== e.h || dirty_o !== e.d || tag_io !== e.bus) begin
        n_bad++;
        $display("FAIL %s: hit/dirty/bus got %b/%b/%h expected %b/%b/%h",
                 e.req, hit, dirty_o, tag_io, e.h, e.d, e.bus);
      end
    end
  end

  task automatic step(input bit w, input bit o, input bit c, input int i,
                      input logic [TAG_W-1:0] t, input bit v, input bit d,
                      input string req);
    exp_t e;
    @(negedge clk);
    wr_n = ~w; oe_n = ~o; clr_n = ~c;
    idx = IDX_W'(i); tb_tag = t; vld_i = v; dty_i = d;
    tb_drv = !c && !o;
    e.req = req;
    if (c) begin
      e.h = 0; e.d = 0; e.bus = {TAG_W{1'bz}};
    end else if (w) begin
      e.h = 0; e.d = d; e.bus = tb_drv ? t : {TAG_W{1'bz}};
    end else if (o) begin
      e.h = 0; e.d = m_d[i]; e.bus = m_tag[i];
    end else begin
      e.h = m_v[i] && (t == m_tag[i]); e.d = m_d[i]; e.bus = t;
    end
    q.push_back(e);
    @(posedge clk);
    #1;
    if (c) begin
      m_v = '0; m_d = '0;
    end else if (w && !o && !m_clr_prev) begin
      m_tag[i] = t; m_v[i] = v; m_d[i] = d;
    end
    m_clr_prev = c;
  endtask

  // step(write, read_enable, clear, idx, tag, valid, dirty, req)
  initial begin
    for (int k = 0; k < DEPTH; k++) m_tag[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0,0,0, 3, 8'h00, 0,0, "R11 no hit after reset");
    step(1,0,0, 3, 8'hA5, 1,0, "R6 write outputs / R1 store");
    step(0,0,0, 3, 8'hA5, 0,0, "R1 R3 compare equal valid");
    step(0,0,0, 3, 8'hA4, 0,0, "R3 compare unequal");
    step(0,1,0, 3, 8'h00, 0,0, "R2 async read of tag");
    step(1,0,0, 7, 8'h3C, 0,1, "R6 write dirty passthru");
    step(0,0,0, 7, 8'h3C, 0,0, "R4 equal tag but invalid / R5 dirty");
    step(1,1,0, 3, 8'h11, 0,1, "R7 write with bus enabled");
    step(0,1,0, 3, 8'h00, 0,0, "R7 tag unchanged");
    step(0,0,0, 3, 8'hA5, 0,0, "R7 status unchanged / R5");
    for (int k = 0; k < DEPTH; k++)
      step(1,0,0, k, 8'(k*7+1), 1,1, "R1 fill");
    for (int k = 0; k < DEPTH; k += 5)
      step(0,0,0, k, 8'(k*7+1), 0,0, "R3 R5 hit after fill");
    step(1,0,1, 2, 8'hFF, 0,0, "R9 clear with write strobe");
    step(1,0,0, 9, 8'h42, 1,1, "R10 write on edge after clear release");
    for (int k = 0; k < DEPTH; k++)
      step(0,0,0, k, 8'(k*7+1), 0,0, "R8 R9 all entries invalid");
    step(0,0,0, 9, 8'h42, 0,0, "R10 blocked write left entry empty");
    step(0,0,0, 2, 8'hFF, 0,0, "R9 write during clear dropped");
    step(1,0,0, 9, 8'h42, 1,1, "R1 write accepted later");
    step(0,0,0, 9, 8'h42, 0,0, "R1 R3 hit");
    step(0,0,1, 9, 8'h42, 0,0, "R8 outputs quiet during clear");
    step(0,0,0, 9, 8'h42, 0,0, "R8 entry invalidated");
    step(0,1,0, 9, 8'h00, 0,0, "R2 tag kept across clear");
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule